// File: doc/BRIEF.md
# Interlaced Sync Timing Generator

This block is a timing engine for 2:1 interlaced video. It produces four active-low waveforms: composite sync, composite blank, horizontal drive and vertical drive. It also produces an active-line indicator. The engine counts pixel clocks along each line and counts half-lines down each field. Every edge is taken from a 12-bit configuration word that synchronous reset loads from parameters. The defaults describe a 910-clock line and a field of 525 half-lines, which gives a 525-line frame. Because the field length in half-lines is odd, the second field starts in the middle of a line. No separate interlace offset logic is needed.

Inside the vertical pulse interval, composite sync stops using the normal line-rate sync pulse. It uses pulses at twice the line rate instead: narrow equalization pulses before and after the vertical sync region, and wide serration pulses inside it. A clock-enable input gates counting. A run flag, loaded at reset from bit 10 of a status parameter, must also be set for counting to happen. A restart input from the command decoder holds the engine at its starting position while it is high. Counting resumes from that position once restart is released.

Top module: `vsync_timing_gen`

## Requirements
- R1: While reset is high, and on the first sample after it falls, the engine is at clock 1 of half-line 1 of the odd field. With the default parameters the outputs then read csync_n=1, cblank_n=0, hdrive_n=0, vdrive_n=0, active_n=1.
- R2: The horizontal position runs 1..H_TOTAL and wraps to 1. It advances by one on each clock where `ce` is 1 and the run flag is set. When `ce` is 0 the outputs hold.
- R3: If bit 10 of the STATUS parameter is 0, the engine never advances, whatever `ce` does.
- R4: The half-line counter advances as the horizontal position leaves H_TOTAL/2 and as it leaves H_TOTAL. It wraps after V_HALF_LINES and toggles the field when it wraps. As a result, half-line 1 of the even field begins at horizontal position H_TOTAL/2+1.
- R5: Outside the pulse interval (half-lines PI_START to PI_END-1), csync_n is 0 exactly when the horizontal position is in [HFP_END, HSYNC_END).
- R6: Inside the pulse interval, when the half-line is below VFP_END or at or above VSYNC_END, csync_n is 0 exactly when the phase is in [HFP_END, EQ_END). The phase is the horizontal position, minus H_TOTAL/2 in the second half of the line.
- R7: When the half-line is in [VFP_END, VSYNC_END), csync_n is 0 exactly when the phase is in [HFP_END, SERR_START).
- R8: cblank_n is 0 when the horizontal position is below HBLANK_END or the half-line is below VBLANK_END. Composite sync is never low while blank is high.
- R9: hdrive_n is 0 inside the horizontal window [HDRV_START, HDRV_END). When the start exceeds the end, the window wraps through the end of the line, so a start of H_TOTAL+1 makes the pulse begin at position 1.
- R10: vdrive_n is 0 inside the half-line window [VDRV_START, VDRV_END), using the same wrap rule.
- R11: active_n is 0 inside the half-line window [VINT_START, VINT_END), using the same wrap rule.
- R12: While `restart` is 1, the engine is forced to its starting position, overriding `ce`. The first enabled clock after release moves it to horizontal position 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset; loads the edge configuration |
| ce | input | 1 | Clock enable for the counters |
| restart | input | 1 | Hold at start position while high |
| csync_n | output | 1 | Composite sync, active low |
| cblank_n | output | 1 | Composite blank, active low |
| hdrive_n | output | 1 | Horizontal drive, active low |
| vdrive_n | output | 1 | Vertical drive, active low |
| active_n | output | 1 | Active-line indicator, active low |

## Verification
Two controls can act on the counters in the same cycle: restart and the clock enable. The bench holds `ce` high for several clocks while `restart` is asserted, in the middle of a field. It then confirms that the outputs show the starting pattern, not an advanced position. After release, one enabled clock must produce the pattern of horizontal position 2. A reduced format, 20 clocks by 21 half-lines, makes the even-field start in mid-line and the frame wrap reachable. The default format is checked along the first forty-odd half-lines.

// File: rtl/sg_pkg.sv
package sg_pkg;

    localparam int TW = 12;

    typedef logic [TW-1:0] cnt_t;

    typedef struct packed {
        cnt_t hfp_end;
        cnt_t hsync_end;
        cnt_t hblank_end;
        cnt_t hdrv_start;
        cnt_t hdrv_end;
        cnt_t vfp_end;
        cnt_t vsync_end;
        cnt_t vblank_end;
        cnt_t vdrv_start;
        cnt_t vdrv_end;
        cnt_t eq_end;
        cnt_t serr_start;
        cnt_t pint_start;
        cnt_t pint_end;
        cnt_t vint_start;
        cnt_t vint_end;
    } sg_cfg_t;

    typedef struct packed {
        logic csync_n;
        logic cblank_n;
        logic hdrive_n;
        logic vdrive_n;
        logic active_n;
    } sg_out_t;

    typedef enum logic [1:0] {
        SEG_NORMAL,
        SEG_EQUAL,
        SEG_SERR
    } sg_seg_e;

    // Half-open window [s, e); wraps through the counter end when s > e.
    function automatic logic in_window(input cnt_t x, input cnt_t s, input cnt_t e);
        if (s <= e) return (x >= s) && (x < e);
        else        return (x >= s) || (x < e);
    endfunction

endpackage

// File: rtl/sg_hcounter.sv
module sg_hcounter
    import sg_pkg::*;
#(
    parameter int HTOT = 910
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic adv,
    output cnt_t hc
);
    localparam cnt_t LAST = cnt_t'(HTOT);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            hc <= cnt_t'(1);
        end else if (adv) begin
            hc <= (hc == LAST) ? cnt_t'(1) : hc + cnt_t'(1);
        end
    end
endmodule

// File: rtl/sg_vcounter.sv
module sg_vcounter
    import sg_pkg::*;
#(
    parameter int HTOT = 910,
    parameter int VT   = 525
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic adv,
    input  cnt_t hc,
    output cnt_t hh,
    output logic field
);
    localparam cnt_t HALF_C = cnt_t'(HTOT / 2);
    localparam cnt_t LAST_C = cnt_t'(HTOT);
    localparam cnt_t VT_C   = cnt_t'(VT);

    logic boundary;
    assign boundary = adv && ((hc == HALF_C) || (hc == LAST_C));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            hh    <= cnt_t'(1);
            field <= 1'b0;
        end else if (boundary) begin
            if (hh == VT_C) begin
                hh    <= cnt_t'(1);
                field <= ~field;
            end else begin
                hh <= hh + cnt_t'(1);
            end
        end
    end
endmodule

// File: rtl/sg_decode.sv
module sg_decode
    import sg_pkg::*;
#(
    parameter int HTOT = 910
) (
    input  sg_cfg_t cfg,
    input  cnt_t    hc,
    input  cnt_t    hh,
    output sg_out_t o
);
    localparam cnt_t HALF_C = cnt_t'(HTOT / 2);

    cnt_t    phase;
    sg_seg_e seg;
    logic    sync;
    logic    blank;

    always_comb begin
        phase = (hc > HALF_C) ? (hc - HALF_C) : hc;

        if (!((hh >= cfg.pint_start) && (hh < cfg.pint_end)))
            seg = SEG_NORMAL;
        else if ((hh >= cfg.vfp_end) && (hh < cfg.vsync_end))
            seg = SEG_SERR;
        else
            seg = SEG_EQUAL;

        case (seg)
            SEG_EQUAL: sync = (phase >= cfg.hfp_end) && (phase < cfg.eq_end);
            SEG_SERR:  sync = (phase >= cfg.hfp_end) && (phase < cfg.serr_start);
            default:   sync = (hc >= cfg.hfp_end) && (hc < cfg.hsync_end);
        endcase

        blank = (hc < cfg.hblank_end) || (hh < cfg.vblank_end);

        o.csync_n  = ~sync;
        o.cblank_n = ~blank;
        o.hdrive_n = ~in_window(hc, cfg.hdrv_start, cfg.hdrv_end);
        o.vdrive_n = ~in_window(hh, cfg.vdrv_start, cfg.vdrv_end);
        o.active_n = ~in_window(hh, cfg.vint_start, cfg.vint_end);
    end
endmodule

// File: rtl/vsync_timing_gen.sv
module vsync_timing_gen
    import sg_pkg::*;
#(
    parameter int          H_TOTAL      = 910,
    parameter int          V_HALF_LINES = 525,
    parameter logic [11:0] STATUS       = 12'h400,
    parameter int          HFP_END      = 23,
    parameter int          HSYNC_END    = 91,
    parameter int          HBLANK_END   = 157,
    parameter int          HDRV_START   = 911,
    parameter int          HDRV_END     = 92,
    parameter int          VFP_END      = 7,
    parameter int          VSYNC_END    = 13,
    parameter int          VBLANK_END   = 41,
    parameter int          VDRV_START   = 1,
    parameter int          VDRV_END     = 21,
    parameter int          EQ_END       = 57,
    parameter int          SERR_START   = 410,
    parameter int          PI_START     = 1,
    parameter int          PI_END       = 19,
    parameter int          VINT_START   = 41,
    parameter int          VINT_END     = 526
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic restart,
    output logic csync_n,
    output logic cblank_n,
    output logic hdrive_n,
    output logic vdrive_n,
    output logic active_n
);
    localparam int   RUN_BIT = 10;
    localparam logic RUN_DEF = STATUS[RUN_BIT];

    sg_cfg_t cfg;
    logic    run_q;
    logic    adv;
    cnt_t    hc;
    cnt_t    hh;
    logic    field;
    sg_out_t outs;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= RUN_DEF;
            cfg   <= '{
                hfp_end:    cnt_t'(HFP_END),
                hsync_end:  cnt_t'(HSYNC_END),
                hblank_end: cnt_t'(HBLANK_END),
                hdrv_start: cnt_t'(HDRV_START),
                hdrv_end:   cnt_t'(HDRV_END),
                vfp_end:    cnt_t'(VFP_END),
                vsync_end:  cnt_t'(VSYNC_END),
                vblank_end: cnt_t'(VBLANK_END),
                vdrv_start: cnt_t'(VDRV_START),
                vdrv_end:   cnt_t'(VDRV_END),
                eq_end:     cnt_t'(EQ_END),
                serr_start: cnt_t'(SERR_START),
                pint_start: cnt_t'(PI_START),
                pint_end:   cnt_t'(PI_END),
                vint_start: cnt_t'(VINT_START),
                vint_end:   cnt_t'(VINT_END)
            };
        end
    end

    assign adv = ce && run_q;

    sg_hcounter #(.HTOT(H_TOTAL)) u_hcnt (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .adv     (adv),
        .hc      (hc)
    );

    sg_vcounter #(.HTOT(H_TOTAL), .VT(V_HALF_LINES)) u_vcnt (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .adv     (adv),
        .hc      (hc),
        .hh      (hh),
        .field   (field)
    );

    sg_decode #(.HTOT(H_TOTAL)) u_dec (
        .cfg (cfg),
        .hc  (hc),
        .hh  (hh),
        .o   (outs)
    );

    assign csync_n  = outs.csync_n;
    assign cblank_n = outs.cblank_n;
    assign hdrive_n = outs.hdrive_n;
    assign vdrive_n = outs.vdrive_n;
    assign active_n = outs.active_n;
endmodule

// File: rtl/sg_checker.sv
module sg_checker
    import sg_pkg::*;
#(
    parameter int HTOT = 910,
    parameter int VT   = 525
) (
    input logic clk,
    input logic rst,
    input logic restart,
    input logic adv,
    input cnt_t hc,
    input cnt_t hh,
    input logic field,
    input logic csync_n,
    input logic cblank_n
);
    localparam cnt_t LAST_C = cnt_t'(HTOT);
    localparam cnt_t HALF_C = cnt_t'(HTOT / 2);
    localparam cnt_t VT_C   = cnt_t'(VT);

    p_hc_range_r2: assert property (@(posedge clk) disable iff (rst)
        (hc >= cnt_t'(1)) && (hc <= LAST_C));

    p_hc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && !restart && hc != LAST_C) |=> (hc == $past(hc) + cnt_t'(1)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!adv && !restart) |=> ($stable(hc) && $stable(hh) && $stable(field)));

    p_hh_range_r4: assert property (@(posedge clk) disable iff (rst)
        (hh >= cnt_t'(1)) && (hh <= VT_C));

    p_field_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (adv && !restart && hh == VT_C && (hc == LAST_C || hc == HALF_C))
        |=> (hh == cnt_t'(1) && field != $past(field)));

    p_sync_in_blank_r8: assert property (@(posedge clk) disable iff (rst)
        !csync_n |-> !cblank_n);

    p_restart_home_r12: assert property (@(posedge clk) disable iff (rst)
        restart |=> (hc == cnt_t'(1) && hh == cnt_t'(1) && !field));
endmodule

bind vsync_timing_gen sg_checker #(.HTOT(H_TOTAL), .VT(V_HALF_LINES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .adv      (adv),
    .hc       (hc),
    .hh       (hh),
    .field    (field),
    .csync_n  (csync_n),
    .cblank_n (cblank_n)
);

// File: tb/sim_vsync_timing_gen.sv
module sim_vsync_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 60000;
    localparam int NVEC       = 21;

    typedef struct packed {
        int         t;
        logic [4:0] e;   // {csync_n, cblank_n, hdrive_n, vdrive_n, active_n}
    } vec_t;

    // Default format, clocks since reset release.
    localparam vec_t TAB [NVEC] = '{
        '{0,     5'b10001},  // R1 start pattern
        '{22,    5'b00001},  // R6 equalization begins
        '{55,    5'b00001},  // R6 last equalization clock
        '{56,    5'b10001},  // R6 equalization ended
        '{91,    5'b10101},  // R9 hdrive ends at 92
        '{157,   5'b10101},  // R8 vertical blank holds
        '{477,   5'b00101},  // R6 second-half equalization
        '{2730,  5'b10001},  // R7 serration half-line start
        '{2752,  5'b00001},  // R7 serration low
        '{3138,  5'b00101},  // R7 serration last low
        '{3139,  5'b10101},  // R7 serration notch
        '{5490,  5'b00001},  // R6 post-equalization
        '{5520,  5'b10001},  // R6 post-equalization end
        '{8220,  5'b00001},  // R5 normal hsync
        '{8281,  5'b10101},  // R5 hsync over
        '{8675,  5'b10101},  // R5 no mid-line pulse
        '{9099,  5'b10101},  // R10 vdrive still low
        '{9100,  5'b10011},  // R10 vdrive released
        '{18199, 5'b10111},  // R8 last blanked half-line
        '{18200, 5'b10010},  // R11 active region starts
        '{18400, 5'b11110}   // R8 blank released
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce1 = 1'b1;
    logic rs1 = 1'b0;

    logic cs0, cb0, hd0, vd0, ac0;
    logic cs1, cb1, hd1, vd1, ac1;
    logic cs2, cb2, hd2, vd2, ac2;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vsync_timing_gen u0 (
        .clk(clk), .rst(rst), .ce(1'b1), .restart(1'b0),
        .csync_n(cs0), .cblank_n(cb0), .hdrive_n(hd0), .vdrive_n(vd0), .active_n(ac0)
    );

    vsync_timing_gen #(
        .H_TOTAL(20), .V_HALF_LINES(21), .STATUS(12'h400),
        .HFP_END(2), .HSYNC_END(6), .HBLANK_END(8), .HDRV_START(21), .HDRV_END(5),
        .VFP_END(3), .VSYNC_END(5), .VBLANK_END(9), .VDRV_START(1), .VDRV_END(4),
        .EQ_END(4), .SERR_START(8), .PI_START(1), .PI_END(7),
        .VINT_START(9), .VINT_END(22)
    ) u1 (
        .clk(clk), .rst(rst), .ce(ce1), .restart(rs1),
        .csync_n(cs1), .cblank_n(cb1), .hdrive_n(hd1), .vdrive_n(vd1), .active_n(ac1)
    );

    vsync_timing_gen #(
        .H_TOTAL(20), .V_HALF_LINES(21), .STATUS(12'h000),
        .HFP_END(2), .HSYNC_END(6), .HBLANK_END(8), .HDRV_START(21), .HDRV_END(5),
        .VFP_END(3), .VSYNC_END(5), .VBLANK_END(9), .VDRV_START(1), .VDRV_END(4),
        .EQ_END(4), .SERR_START(8), .PI_START(1), .PI_END(7),
        .VINT_START(9), .VINT_END(22)
    ) u2 (
        .clk(clk), .rst(rst), .ce(1'b1), .restart(1'b0),
        .csync_n(cs2), .cblank_n(cb2), .hdrive_n(hd2), .vdrive_n(vd2), .active_n(ac2)
    );

    wire [4:0] o0 = {cs0, cb0, hd0, vd0, ac0};
    wire [4:0] o1 = {cs1, cb1, hd1, vd1, ac1};
    wire [4:0] o2 = {cs2, cb2, hd2, vd2, ac2};

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired (no requirement) actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int cur;
        repeat (3) @(negedge clk);
        chk("R1 reset held u0", o0, 5'b10001);
        rst = 1'b0;
        cur = 0;
        for (int i = 0; i < NVEC; i++) begin
            adv(TAB[i].t - cur);
            cur = TAB[i].t;
            chk($sformatf("default-format vector %0d at clock %0d", i, cur), o0, TAB[i].e);
        end

        // Reduced format section
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 start u1", o1, 5'b10001);
        chk("R1 start u2", o2, 5'b10001);
        adv(1);
        chk("R6 first equalization clock u1", o1, 5'b00001);
        ce1 = 1'b0;
        adv(5);
        chk("R2 hold while ce low", o1, 5'b00001);
        chk("R3 run bit clear never advances", o2, 5'b10001);
        ce1 = 1'b1;
        adv(208);   // t=209
        chk("R4 last odd half-line", o1, 5'b11110);
        adv(1);     // t=210
        chk("R4 even field starts mid-line", o1, 5'b10101);
        adv(1);     // t=211
        chk("R6 even-field equalization", o1, 5'b00101);
        adv(25);    // t=236
        chk("R7 serration low", o1, 5'b00101);
        adv(1);     // t=237
        chk("R7 serration notch", o1, 5'b10101);
        adv(52);    // t=289
        chk("R8 even-field vertical blank", o1, 5'b10111);
        adv(1);     // t=290
        chk("R11 even-field active region", o1, 5'b11110);
        adv(129);   // t=419
        chk("R4 last even half-line", o1, 5'b11110);
        adv(1);     // t=420
        chk("R4 frame wraps to odd field", o1, 5'b10001);
        adv(3);     // t=423
        chk("R9 wrapped hdrive last clock", o1, 5'b10001);
        adv(1);     // t=424
        chk("R9 wrapped hdrive released", o1, 5'b10101);
        adv(25);    // t=449
        chk("R10 vdrive last half-line", o1, 5'b10101);
        adv(1);     // t=450
        chk("R10 vdrive released", o1, 5'b10111);

        rs1 = 1'b1;  // ce1 stays high: restart must win
        adv(3);
        chk("R12 restart overrides enable", o1, 5'b10001);
        rs1 = 1'b0;
        chk("R12 start held at release", o1, 5'b10001);
        adv(1);
        chk("R12 resumes at position 2", o1, 5'b00001);
        chk("R3 still idle at end", o2, 5'b10001);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule